// File: doc/BRIEF.md
# Restoring Long Divider with Sliding Divisor

This block divides one unsigned N-bit integer by another over several clock cycles. An operand pair enters through a valid/ready handshake. The block then runs a restoring long-division loop in a working area twice as wide as the operands. The divisor is loaded into the high half of a 2N-bit register and moves one place toward the low end on every step. The remainder register starts out holding the dividend. Each step makes a trial subtraction. When the trial does not go negative, the difference is kept and a 1 enters the quotient from the right. When it does go negative, the remainder keeps its old value and a 0 enters instead. The loop runs N+1 steps, so every quotient bit is formed and the final remainder sits in the low N bits.

Results leave through a second valid/ready handshake. Back-pressure works as follows. While `out_valid` is high and `out_ready` is low, the quotient, remainder and zero-divisor flag hold their values. No new operands are taken during that time. The block accepts operands only when idle, so one division is in flight at a time. A zero divisor is not trapped. It runs the normal loop, which returns an all-ones quotient and the dividend as the remainder, and it raises a flag alongside the result.

Top module: `restoring_divider`

## Requirements
- R1: `in_ready` is high only when no division is in progress and no result is pending. Operands transfer on a rising edge where `in_valid` and `in_ready` are both high, and `in_ready` is low in the cycle after a transfer.
- R2: `out_valid` rises exactly N+1 rising edges after the edge on which operands transferred.
- R3: For a nonzero divisor, the presented `quotient` is floor(dividend/divisor) and `remainder` is dividend mod divisor. Hence quotient*divisor+remainder equals the dividend, and remainder is less than divisor.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid`, `quotient`, `remainder` and `div_by_zero` hold their values, and `in_ready` stays low.
- R5: For a divisor of zero, `quotient` is all ones, `remainder` equals the dividend, and `div_by_zero` is 1. For any nonzero divisor, `div_by_zero` is 0.
- R6: After a rising edge with `out_valid` and `out_ready` both high, `out_valid` is low and `in_ready` is high.
- R7: While `rst_n` is low (active-low, synchronous), `in_ready` is 1, `out_valid` is 0, and `quotient`, `remainder` and `div_by_zero` are 0.
- R8: Operand values and `in_valid` presented while a division is in progress or a result is pending have no effect on that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair is offered |
| in_ready | output | 1 | Block can take an operand pair |
| dividend | input | N | Unsigned dividend |
| divisor | input | N | Unsigned divisor |
| out_valid | output | 1 | Result is presented |
| out_ready | input | 1 | Consumer takes the result |
| quotient | output | N | Unsigned quotient |
| remainder | output | N | Unsigned remainder |
| div_by_zero | output | 1 | Divisor of the presented result was zero |

## Verification
The bench runs every 6-bit operand pair, including all zero divisors and octal 74 by 21 (expected quotient 3, remainder 9). This catches a sign test taken from bit 2N-1 instead of the borrow. That faulty design misreads large trial differences as positive and returns wrong quotients when the divisor's top bit is set. Results are held with `out_ready` low for varying spans, and fresh operands are offered during busy and pending cycles. A design that drops its hold, or accepts a pair early, would change or corrupt the presented result. Step count and handshake timing are compared cycle by cycle against a behavioural model, so an off-by-one iteration count shows up as a latency error or a wrong quotient bit.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } div_state_e;
endpackage

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int N = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       out_ready,
  output div_state_e state,
  output logic       load,
  output logic       step
);
  localparam int CW = $clog2(N + 1) + 1;
  localparam logic [CW-1:0] LAST = CW'(N);

  logic [CW-1:0] iter_q;

  assign load = (state == ST_IDLE) && in_valid;
  assign step = (state == ST_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      iter_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (in_valid) begin
          state  <= ST_RUN;
          iter_q <= '0;
        end
        ST_RUN: begin
          iter_q <= iter_q + 1'b1;
          if (iter_q == LAST) state <= ST_DONE;
        end
        ST_DONE: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/div_step.sv
module div_step #(
  parameter int N = 6
) (
  input  logic [2*N-1:0] rem_in,
  input  logic [2*N-1:0] dvs_in,
  output logic [2*N-1:0] rem_out,
  output logic           q_bit
);
  localparam int W = 2 * N;

  logic [W:0] trial;

  // One extra bit so the borrow, not bit W-1, decides the sign.
  assign trial   = {1'b0, rem_in} - {1'b0, dvs_in};
  assign q_bit   = ~trial[W];
  assign rem_out = q_bit ? trial[W-1:0] : rem_in;
endmodule

// File: rtl/div_datapath.sv
module div_datapath #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [N-1:0] dividend,
  input  logic [N-1:0] divisor,
  output logic [N-1:0] quotient,
  output logic [N-1:0] remainder,
  output logic         div_by_zero
);
  localparam int W = 2 * N;

  logic [W-1:0] rem_q, dvs_q, rem_nx;
  logic [N-1:0] quo_q;
  logic         zero_q, q_bit;

  div_step #(.N(N)) u_step (
    .rem_in (rem_q),
    .dvs_in (dvs_q),
    .rem_out(rem_nx),
    .q_bit  (q_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= '0;
      dvs_q  <= '0;
      quo_q  <= '0;
      zero_q <= 1'b0;
    end else if (load) begin
      rem_q  <= {{N{1'b0}}, dividend};
      dvs_q  <= {divisor, {N{1'b0}}};
      quo_q  <= '0;
      zero_q <= (divisor == '0);
    end else if (step) begin
      rem_q <= rem_nx;
      dvs_q <= dvs_q >> 1;
      quo_q <= {quo_q[N-2:0], q_bit};
    end
  end

  assign quotient    = quo_q;
  assign remainder   = rem_q[N-1:0];
  assign div_by_zero = zero_q;
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider
  import div_pkg::*;
#(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] dividend,
  input  logic [N-1:0] divisor,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [N-1:0] quotient,
  output logic [N-1:0] remainder,
  output logic         div_by_zero
);
  div_state_e state;
  logic       load, step;

  div_ctrl #(.N(N)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .out_ready(out_ready),
    .state    (state),
    .load     (load),
    .step     (step)
  );

  div_datapath #(.N(N)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .step       (step),
    .dividend   (dividend),
    .divisor    (divisor),
    .quotient   (quotient),
    .remainder  (remainder),
    .div_by_zero(div_by_zero)
  );

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_DONE);
endmodule

// File: rtl/restoring_divider_chk.sv
module restoring_divider_chk #(
  parameter int N = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [N-1:0] dividend,
  input logic [N-1:0] divisor,
  input logic         out_valid,
  input logic         out_ready,
  input logic [N-1:0] quotient,
  input logic [N-1:0] remainder,
  input logic         div_by_zero
);
  logic [N-1:0] cap_a, cap_b;
  logic [15:0]  lat_cnt;
  logic         busy;
  logic [2*N-1:0] recon;

  assign recon = {{N{1'b0}}, quotient} * {{N{1'b0}}, cap_b} + {{N{1'b0}}, remainder};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_a <= '0; cap_b <= '0; lat_cnt <= '0; busy <= 1'b0;
    end else if (in_valid && in_ready) begin
      cap_a <= dividend; cap_b <= divisor; lat_cnt <= '0; busy <= 1'b1;
    end else if (busy && !out_valid) begin
      lat_cnt <= lat_cnt + 16'd1;
    end else if (out_valid && out_ready) begin
      busy <= 1'b0;
    end
  end

  assert_ready_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat_cnt == 16'(N + 1)));
  assert_rem_lt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cap_b != '0) |-> (remainder < cap_b));
  assert_recon_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cap_b != '0) |-> (recon == {{N{1'b0}}, cap_a}));
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && !in_ready && $stable(quotient)
      && $stable(remainder) && $stable(div_by_zero)));
  assert_zero_div_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cap_b == '0) |-> (div_by_zero && (&quotient) && remainder == cap_a));
  assert_flag_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cap_b != '0) |-> !div_by_zero);
  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (in_ready && !out_valid));
endmodule

bind restoring_divider restoring_divider_chk #(.N(N)) u_chk (.*);

// File: tb/restoring_divider_bench.sv
module restoring_divider_bench;
  localparam int N = 6;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [N-1:0] dividend = '0, divisor = '0;
  logic in_ready, out_valid, div_by_zero;
  logic [N-1:0] quotient, remainder;

  int checks = 0, failures = 0;
  bit finished = 0;

  // behavioural reference model: 0 idle, 1 busy, 2 result pending
  int m_state = 0, m_left = 0, m_q = 0, m_r = 0, m_z = 0, m_a = 0, m_b = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  restoring_divider #(.N(N)) u_restoring_divider (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .dividend(dividend), .divisor(divisor), .out_valid(out_valid),
    .out_ready(out_ready), .quotient(quotient), .remainder(remainder),
    .div_by_zero(div_by_zero)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state <= 0;
    end else begin
      case (m_state)
        0: if (in_valid) begin
          m_state <= 1;
          m_left  <= N + 1;
          m_a     <= int'(dividend);
          m_b     <= int'(divisor);
          m_z     <= (divisor == 0) ? 1 : 0;
          m_q     <= (divisor == 0) ? (1 << N) - 1 : int'(dividend) / int'(divisor);
          m_r     <= (divisor == 0) ? int'(dividend) : int'(dividend) % int'(divisor);
        end
        1: begin
          m_left <= m_left - 1;
          if (m_left == 1) m_state <= 2;
        end
        default: if (out_ready) m_state <= 0;
      endcase
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(in_ready == (m_state == 0), "R1 in_ready", int'(in_ready), int'(m_state == 0));
      chk(out_valid == (m_state == 2), "R2 out_valid timing", int'(out_valid), int'(m_state == 2));
      if (m_state == 2 && out_valid) begin
        chk(int'(quotient) == m_q, "R3/R8 quotient", int'(quotient), m_q);
        chk(int'(remainder) == m_r, "R3/R8 remainder", int'(remainder), m_r);
        chk(int'(div_by_zero) == m_z, "R5 div_by_zero", int'(div_by_zero), m_z);
        if (m_b != 0) begin
          chk(int'(quotient) * m_b + int'(remainder) == m_a, "R3 q*d+r", 
              int'(quotient) * m_b + int'(remainder), m_a);
          chk(int'(remainder) < m_b, "R3 r<d", int'(remainder), m_b);
        end
        if (m_a == 'o74 && m_b == 'o21) begin
          chk(int'(quotient) == 3, "R3 octal 74/21 quotient", int'(quotient), 3);
          chk(int'(remainder) == 9, "R3 octal 74/21 remainder", int'(remainder), 9);
        end
      end
    end
  end

  task automatic run_one(input int a, input int b, input int stall);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    dividend = N'(a);
    divisor  = N'(b);
    @(negedge clk);
    // R8: junk offered while busy must not alter the result
    dividend = N'(~a);
    divisor  = N'(b ^ 5);
    while (!out_valid) @(negedge clk);
    for (int k = 0; k < stall; k++) begin
      chk(!in_ready, "R4 no accept while pending", int'(in_ready), 0);
      @(negedge clk);
    end
    in_valid  = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    chk(!out_valid && in_ready, "R6 release", int'(out_valid), 0);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R7 reset in_ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R7 reset out_valid", int'(out_valid), 0);
    chk(quotient == '0 && remainder == '0, "R7 reset result", int'(quotient), 0);
    chk(div_by_zero == 1'b0, "R7 reset flag", int'(div_by_zero), 0);
    rst_n = 1'b1;
    run_one('o74, 'o21, 2);
    for (int a = 0; a < (1 << N); a++)
      for (int b = 0; b < (1 << N); b++)
        run_one(a, b, (a + b) % 3);
    repeat (2) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule